// File: doc/BRIEF.md
# Serial Interrupt Frame Generator

This block sits on the peripheral side of a single shared, open-drain serial interrupt wire that runs beside a low-pin-count host bus. It watches the wire for a host start frame, then counts sixteen three-clock slots. In the sample clock of each slot whose interrupt request is active, it pulls the wire low. It drives the wire high for the next clock and then lets it go. At the end of the frame it reads the stop frame to learn whether the host wants quiet or continuous operation.

Three request channels feed the slots. The first channel carries two keyboard-style interrupts. The second and third channels each carry a system-management request and four general interrupts. Requests that land on the same slot from these two channels are merged. In quiet mode the host sends no frames on its own. When the request set differs from the one last reported, the peripheral asks for a frame by pulling the wire low for one clock. In continuous mode the peripheral never asks and only follows frames that the host starts.

The wire is modelled as a drive-enable plus a drive value; the line value as seen on the wire comes back on a separate input.

Top module: `sirq_frame_gen`

## Requirements
- R1: A low run on `sirq_in` lasting 4 to 8 clocks, followed by a high clock, starts a frame. The sample clock of slot 0 is the clock right after the first high sample.
- R2: A frame has 16 slots of 3 clocks each (sample, recovery, turnaround). The sample clock of slot n comes 3n clocks after that of slot 0.
- R3: `ch1_req` bit 0 is reported in slot 1 and bit 1 in slot 12.
- R4: Bits of `ch2_req` and `ch3_req` map as follows: bit 0 (system-management) to slot 2, bit 1 to slot 6, bit 2 to slot 9, bit 3 to slot 10 and bit 4 to slot 11. The two channels are ORed per slot.
- R5: For an active slot, the block drives 0 in the sample clock and 1 in the recovery clock, and releases the wire in the turnaround clock. An inactive slot is never driven.
- R6: A low run shorter than 4 or longer than 8 clocks is ignored, and no slot is driven after it.
- R7: Mode comes from the stop frame that follows slot 15. Two low clocks select quiet (`quiet_mode`=1) and three select continuous (`quiet_mode`=0). Continuous is the mode out of reset.
- R8: In quiet mode, an idle block whose request set differs from the one captured at the last frame start drives 0 for exactly one clock and then releases.
- R9: The block makes no start request in continuous mode, nor in quiet mode while the request set is unchanged since the last frame.
- R10: If the host pulls the wire low in the same clock in which a quiet-mode request would begin, the host's start wins. The block does not drive, and the frame then reports the new requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sirq_in | input | 1 | Resolved level of the serial interrupt wire |
| ch1_req | input | 2 | Channel 1 requests (bit0 slot 1, bit1 slot 12) |
| ch2_req | input | 5 | Channel 2 requests (management, 6, 9, 10, 11) |
| ch3_req | input | 5 | Channel 3 requests (same layout as channel 2) |
| sirq_oe | output | 1 | Drive enable for the wire |
| sirq_do | output | 1 | Value driven when enabled |
| quiet_mode | output | 1 | 1 = quiet mode, 0 = continuous mode |

## Verification
The two functions that can land in the same clock are the peripheral's own start request and the host's start of a frame. The bench brings them together by changing a request in quiet mode in the same cycle in which the host's model pulls the wire low. The result is judged at the ports: the drive enable must stay low in the next clock, and the frame that follows must carry the new request pattern in the right slots. The bench also sweeps every request bit on its own and several mixes, using start lengths of 4 to 8 clocks. It computes the expected three-clock drive pattern of every slot from the mapping.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_START,
        ST_SAMPLE,
        ST_RECOV,
        ST_TURN,
        ST_STOPW,
        ST_STOPC
    } sirq_state_e;

    localparam int LANE_W = 5;

endpackage

// File: rtl/sirq_slot_map.sv
module sirq_slot_map #(
    parameter int NUM_SLOTS  = 16,
    parameter int NUM_SHARED = 2,
    parameter int KBD_SLOT   = 1,
    parameter int AUX_SLOT   = 12,
    parameter int MGMT_SLOT  = 2,
    parameter int GEN0_SLOT  = 6,
    parameter int GEN1_SLOT  = 9,
    parameter int GEN2_SLOT  = 10,
    parameter int GEN3_SLOT  = 11
) (
    input  logic [1:0]                              ch1_req,
    input  logic [NUM_SHARED*sirq_pkg::LANE_W-1:0]  shared_req,
    output logic [NUM_SLOTS-1:0]                    slot_req
);
    import sirq_pkg::*;

    logic [LANE_W-1:0] lane [NUM_SHARED];
    logic [LANE_W-1:0] merged;

    for (genvar c = 0; c < NUM_SHARED; c++) begin : g_lane
        assign lane[c] = shared_req[c*LANE_W +: LANE_W];
    end

    always_comb begin
        merged = '0;
        for (int c = 0; c < NUM_SHARED; c++) begin
            merged = merged | lane[c];
        end
        slot_req            = '0;
        slot_req[KBD_SLOT]  = ch1_req[0];
        slot_req[AUX_SLOT]  = ch1_req[1];
        slot_req[MGMT_SLOT] = merged[0];
        slot_req[GEN0_SLOT] = merged[1];
        slot_req[GEN1_SLOT] = merged[2];
        slot_req[GEN2_SLOT] = merged[3];
        slot_req[GEN3_SLOT] = merged[4];
    end

endmodule

// File: rtl/sirq_change_detect.sv
module sirq_change_detect #(
    parameter int NUM_SLOTS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic [NUM_SLOTS-1:0] cur_req,
    output logic                 pending
);
    logic [NUM_SLOTS-1:0] sent_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent_q <= '0;
        end else if (capture) begin
            sent_q <= cur_req;
        end
    end

    assign pending = (sent_q != cur_req);

endmodule

// File: rtl/sirq_frame_fsm.sv
module sirq_frame_fsm #(
    parameter int NUM_SLOTS  = 16,
    parameter int START_MIN  = 4,
    parameter int START_MAX  = 8,
    parameter int STOP_QUIET = 2,
    parameter int STOP_CONT  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_in,
    input  logic [NUM_SLOTS-1:0] slot_req,
    input  logic                 pending,
    output logic                 capture,
    output logic                 drv_oe,
    output logic                 drv_do,
    output logic                 quiet_mode
);
    import sirq_pkg::*;

    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int CNT_W  = $clog2(START_MAX + 2);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [CNT_W-1:0]  CNT_SAT   = CNT_W'(START_MAX + 1);
    localparam logic [CNT_W-1:0]  CNT_MIN   = CNT_W'(START_MIN);
    localparam logic [CNT_W-1:0]  CNT_MAX   = CNT_W'(START_MAX);
    localparam logic [CNT_W-1:0]  CNT_QUIET = CNT_W'(STOP_QUIET);
    localparam logic [CNT_W-1:0]  CNT_CONT  = CNT_W'(STOP_CONT);

    sirq_state_e       state_q, state_d;
    logic [SLOT_W-1:0] slot_q,  slot_d;
    logic [CNT_W-1:0]  cnt_q,   cnt_d;
    logic              drove_q, drove_d;
    logic              quiet_q, quiet_d;
    logic [CNT_W-1:0]  cnt_inc;

    assign cnt_inc = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            cnt_q   <= '0;
            drove_q <= 1'b0;
            quiet_q <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            cnt_q   <= cnt_d;
            drove_q <= drove_d;
            quiet_q <= quiet_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        cnt_d   = cnt_q;
        drove_d = drove_q;
        quiet_d = quiet_q;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!line_in) begin
                    state_d = ST_START;
                    cnt_d   = CNT_W'(1);
                end else if (quiet_q && pending) begin
                    state_d = ST_REQ;
                end
            end
            ST_REQ: begin
                state_d = ST_START;
                cnt_d   = CNT_W'(1);
            end
            ST_START: begin
                if (!line_in) begin
                    cnt_d = cnt_inc;
                end else if (cnt_q >= CNT_MIN && cnt_q <= CNT_MAX) begin
                    state_d = ST_SAMPLE;
                    slot_d  = '0;
                    capture = 1'b1;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_SAMPLE: begin
                drove_d = slot_req[slot_q];
                state_d = ST_RECOV;
            end
            ST_RECOV: begin
                state_d = ST_TURN;
            end
            ST_TURN: begin
                drove_d = 1'b0;
                if (slot_q == LAST_SLOT) begin
                    state_d = ST_STOPW;
                end else begin
                    slot_d  = slot_q + 1'b1;
                    state_d = ST_SAMPLE;
                end
            end
            ST_STOPW: begin
                if (!line_in) begin
                    state_d = ST_STOPC;
                    cnt_d   = CNT_W'(1);
                end
            end
            ST_STOPC: begin
                if (!line_in) begin
                    cnt_d = cnt_inc;
                end else begin
                    if (cnt_q == CNT_QUIET) quiet_d = 1'b1;
                    if (cnt_q == CNT_CONT)  quiet_d = 1'b0;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        drv_oe = 1'b0;
        drv_do = 1'b1;
        unique case (state_q)
            ST_REQ: begin
                drv_oe = 1'b1;
                drv_do = 1'b0;
            end
            ST_SAMPLE: begin
                drv_oe = slot_req[slot_q];
                drv_do = 1'b0;
            end
            ST_RECOV: begin
                drv_oe = drove_q;
                drv_do = 1'b1;
            end
            default: begin
                drv_oe = 1'b0;
                drv_do = 1'b1;
            end
        endcase
    end

    assign quiet_mode = quiet_q;

endmodule

// File: rtl/sirq_frame_gen.sv
module sirq_frame_gen #(
    parameter int NUM_SLOTS  = 16,
    parameter int START_MIN  = 4,
    parameter int START_MAX  = 8,
    parameter int STOP_QUIET = 2,
    parameter int STOP_CONT  = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sirq_in,
    input  logic [1:0] ch1_req,
    input  logic [4:0] ch2_req,
    input  logic [4:0] ch3_req,
    output logic       sirq_oe,
    output logic       sirq_do,
    output logic       quiet_mode
);
    localparam int NUM_SHARED = 2;

    logic [NUM_SLOTS-1:0] slot_req;
    logic                 pending;
    logic                 capture;

    sirq_slot_map #(
        .NUM_SLOTS  (NUM_SLOTS),
        .NUM_SHARED (NUM_SHARED)
    ) u_map (
        .ch1_req    (ch1_req),
        .shared_req ({ch3_req, ch2_req}),
        .slot_req   (slot_req)
    );

    sirq_change_detect #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_chg (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .cur_req (slot_req),
        .pending (pending)
    );

    sirq_frame_fsm #(
        .NUM_SLOTS  (NUM_SLOTS),
        .START_MIN  (START_MIN),
        .START_MAX  (START_MAX),
        .STOP_QUIET (STOP_QUIET),
        .STOP_CONT  (STOP_CONT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (sirq_in),
        .slot_req   (slot_req),
        .pending    (pending),
        .capture    (capture),
        .drv_oe     (sirq_oe),
        .drv_do     (sirq_do),
        .quiet_mode (quiet_mode)
    );

endmodule

// File: rtl/sirq_frame_gen_chk.sv
module sirq_frame_gen_chk (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  oe,
    input logic                  dout,
    input logic                  quiet,
    input logic                  line,
    input sirq_pkg::sirq_state_e st
);
    import sirq_pkg::*;

    a_r5_high_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SAMPLE && oe && !dout) |=> (oe && dout));

    a_r5_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && dout) |=> !oe);

    a_r8_low_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !dout) |=> !(oe && !dout));

    a_r9_request_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_REQ) |-> quiet);

    a_r7_mode_from_stop_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_STOPC) |=> $stable(quiet));

    a_r10_host_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && !line) |=> (st == ST_START && !oe));

endmodule

bind sirq_frame_gen sirq_frame_gen_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .oe    (sirq_oe),
    .dout  (sirq_do),
    .quiet (quiet_mode),
    .line  (sirq_in),
    .st    (u_fsm.state_q)
);

// File: tb/sirq_frame_gen_tb.sv
`timescale 1ns/1ps
module sirq_frame_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_l = 1'b1;
    logic [1:0] c1 = '0;
    logic [4:0] c2 = '0;
    logic [4:0] c3 = '0;
    logic       sirq_oe, sirq_do, quiet_mode;
    logic       line;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign line = host_l & ~(sirq_oe & ~sirq_do);

    sirq_frame_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sirq_in    (line),
        .ch1_req    (c1),
        .ch2_req    (c2),
        .ch3_req    (c3),
        .sirq_oe    (sirq_oe),
        .sirq_do    (sirq_do),
        .quiet_mode (quiet_mode)
    );

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // expected slot vector per R3 and R4
    function automatic logic [15:0] exp_vec(logic [1:0] a, logic [4:0] b, logic [4:0] c);
        logic [15:0] v = '0;
        logic [4:0]  m = b | c;
        v[1]  = a[0];
        v[12] = a[1];
        v[2]  = m[0];
        v[6]  = m[1];
        v[9]  = m[2];
        v[10] = m[3];
        v[11] = m[4];
        return v;
    endfunction

    // called at a negedge; n rising edges see the host low
    task automatic host_low(input int n);
        host_l = 1'b0;
        repeat (n) @(negedge clk);
        host_l = 1'b1;
    endtask

    // R2/R5: per slot pattern code: 1 = drive 0, 2 = drive 1, 0 = released
    task automatic check_frame(input logic [15:0] ev, input string tag);
        for (int s = 0; s < 16; s++) begin
            logic [5:0] got = '0;
            logic [5:0] exp;
            for (int p = 0; p < 3; p++) begin
                @(negedge clk);
                got[p*2 +: 2] = sirq_oe ? (sirq_do ? 2'd2 : 2'd1) : 2'd0;
            end
            exp = ev[s] ? 6'b00_10_01 : 6'b00_00_00;
            chk(got == exp, $sformatf("%s slot %0d", tag, s), got, exp);
        end
    endtask

    task automatic send_stop(input int n);
        @(negedge clk);
        host_low(n);
        @(negedge clk);
    endtask

    task automatic watch_idle(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sirq_oe) seen++;
        end
        chk(seen == 0, tag, seen, 0);
    endtask

    task automatic set_word(input logic [11:0] w);
        c1 = w[1:0];
        c2 = w[6:2];
        c3 = w[11:7];
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sirq_oe == 1'b0, "reset drive R5", sirq_oe, 0);
        chk(quiet_mode == 1'b0, "reset mode R7", quiet_mode, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R5: sweep single bits and mixes, start lengths 4..8
        for (int b = 0; b < 16; b++) begin
            logic [11:0] w;
            if (b < 12)       w = 12'(1) << b;
            else if (b == 12) w = 12'hFFF;
            else if (b == 13) w = 12'h0A5;
            else if (b == 14) w = 12'b00110_11000_01;
            else              w = 12'h000;
            set_word(w);
            host_low(4 + (b % 5));
            check_frame(exp_vec(c1, c2, c3), $sformatf("R1 R3 R4 sweep %0d", b));
            send_stop(3);
            chk(quiet_mode == 1'b0, "R7 continuous stop", quiet_mode, 0);
        end

        // R6: too short and too long start runs
        set_word(12'hFFF);
        host_low(3);
        watch_idle(60, "R6 short start");
        host_low(9);
        watch_idle(60, "R6 long start");

        // R9: continuous mode never requests
        set_word(12'h555);
        watch_idle(20, "R9 continuous no request");

        // frame then stop of 2 enters quiet
        host_low(5);
        check_frame(exp_vec(c1, c2, c3), "R2 frame before quiet");
        send_stop(2);
        chk(quiet_mode == 1'b1, "R7 quiet stop", quiet_mode, 1);
        watch_idle(20, "R9 quiet unchanged");

        // R8: quiet request on change
        set_word(12'h556);
        @(negedge clk);
        chk(sirq_oe == 1'b1 && sirq_do == 1'b0, "R8 request low", {sirq_oe, sirq_do}, 2);
        host_l = 1'b0;
        @(negedge clk);
        chk(sirq_oe == 1'b0, "R8 request one clock", sirq_oe, 0);
        host_low(3);
        check_frame(exp_vec(c1, c2, c3), "R8 requested frame");
        send_stop(2);
        watch_idle(20, "R9 pending cleared");

        // R10: host start and request in the same clock
        set_word(12'h80F);
        host_l = 1'b0;
        @(negedge clk);
        chk(sirq_oe == 1'b0, "R10 host start wins", sirq_oe, 0);
        host_low(3);
        check_frame(exp_vec(c1, c2, c3), "R10 frame");
        send_stop(3);
        chk(quiet_mode == 1'b0, "R7 back to continuous", quiet_mode, 0);
        watch_idle(10, "R9 continuous after quiet");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule